// File: doc/BRIEF.md
# Automatic Level Control with Noise Gate

This block sets the 6-bit gain code of a recording amplifier. The aim is to bring the captured signal to a chosen target level. It takes one signed sample on each cycle in which the sample strobe is high, compares the sample's magnitude against a target amplitude, and then moves the gain one 0.75 dB step at a time. Gain codes run from -12 dB at code 0 up to +35.25 dB at code 63, and code 16 is 0 dB. Loud samples drive the gain down at the attack rate. Quiet samples first wait out a hold period and then drive the gain up at the decay rate. The result always stays between a selectable ceiling and a selectable floor.

All time is counted in sample strobes. A step period is a base length shifted left by its code. A limiter mode swaps in shorter base lengths for a faster response. An optional noise gate stops all upward movement while the signal sits below a low threshold, and a flag shows that the gate is active. When the controller is switched off, the gain code follows a manual input.

Top module: `agc_noise_gate`

## Requirements
- R1: After reset the gain code is 16 (0 dB) and the gate flag is 0.
- R2: While alc_en is 0, the gain code equals manual_gain one cycle later, the gate flag is 0 and all timers restart.
- R3: A strobed sample is loud when its magnitude exceeds the target amplitude. The target is -28.5 dBFS + 1.5 dB × target_sel relative to 2^(DW-1). Each loud strobe advances the attack count and clears the hold and decay counts. When the attack count reaches the attack period, the gain drops by one code.
- R4: Only strobes that are neither loud nor gated count as quiet. After reset, an enable or an attack, the first H quiet strobes only fill the hold count. H is 0 for hold_sel 0 and HOLD_BASE << (hold_sel-1) otherwise.
- R5: After the hold, each decay period of quiet strobes raises the gain by one code. Any strobe that is not loud clears the attack count.
- R6: Attack and decay periods equal the base length shifted left by the code. The bases are ATK_ALC/DCY_ALC with lim_mode 0 and ATK_LIM/DCY_LIM with lim_mode 1. A count at or past a shortened period completes at once.
- R7: On every enabled strobe the gain is clamped into [8×min_sel, 8×max_sel+7]. When the floor is above the ceiling, the ceiling wins.
- R8: With gate_en set, a strobe whose magnitude is below (368 << (DW-16)) >> gate_sel (-39 dB down to -81 dB in 6 dB steps) is gated. The gain, hold count and decay count stay unchanged, and the gate flag goes to 1. Every other enabled strobe clears the flag.
- R9: The most negative sample has magnitude 2^(DW-1) and counts as loud for every target.
- R10: On enabled cycles with no strobe, the gain, the gate flag and all counts keep their values.
- R11: Attack and decay codes 10 to 15 all give the period of code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alc_en | input | 1 | 1 = automatic control, 0 = manual gain |
| lim_mode | input | 1 | 1 = fast limiter time bases |
| smp_vld | input | 1 | Sample strobe |
| smp | input | DW | Signed audio sample |
| manual_gain | input | 6 | Gain code used while disabled |
| max_sel | input | 3 | Gain ceiling select |
| min_sel | input | 3 | Gain floor select |
| target_sel | input | 4 | Target level select |
| hold_sel | input | 4 | Hold time code |
| attack_sel | input | 4 | Attack step time code |
| decay_sel | input | 4 | Decay step time code |
| gate_en | input | 1 | Noise gate enable |
| gate_sel | input | 3 | Noise gate threshold select |
| gain_code | output | 6 | Amplifier gain code |
| gate_active | output | 1 | Noise gate holding the gain |

## Verification
Every strobe's effect is registered, so gain_code and gate_active reflect a strobe on the clock edge that captures it. The manual gain also appears one edge after it is applied. Releasing reset adds two more edges through the reset synchronizer, and the bench keeps the block disabled at unity gain across that window. The bench drives inputs at the falling edge and advances its behavioural model with those same inputs. At the next falling edge it compares both outputs against the model, so every cycle is checked at the point where its result is due. Step periods that span thousands of strobes are checked to the exact strobe, because the comparison runs on every clock.

// File: rtl/agc_pkg.sv
package agc_pkg;

  localparam int GAIN_W = 6;
  localparam logic [GAIN_W-1:0] GAIN_UNITY = 6'd16;
  localparam logic [GAIN_W-1:0] GAIN_TOP   = 6'd63;

  // noise gate threshold for select 0 at 16-bit full scale (-39 dB)
  localparam logic [15:0] GATE_BASE16 = 16'd368;

  // target amplitude at 16-bit full scale, -28.5 dBFS + 1.5 dB per code
  function automatic logic [15:0] tgt_amp16(input logic [3:0] sel);
    logic [15:0] v;
    case (sel)
      4'd0:  v = 16'd1231;
      4'd1:  v = 16'd1464;
      4'd2:  v = 16'd1740;
      4'd3:  v = 16'd2068;
      4'd4:  v = 16'd2457;
      4'd5:  v = 16'd2921;
      4'd6:  v = 16'd3471;
      4'd7:  v = 16'd4125;
      4'd8:  v = 16'd4903;
      4'd9:  v = 16'd5827;
      4'd10: v = 16'd6925;
      4'd11: v = 16'd8231;
      4'd12: v = 16'd9783;
      4'd13: v = 16'd11627;
      4'd14: v = 16'd13818;
      default: v = 16'd16423;
    endcase
    return v;
  endfunction

  // ceiling: -6.75 dB + 6 dB per code -> gain code 8k+7
  function automatic logic [GAIN_W-1:0] ceil_code(input logic [2:0] k);
    return {k, 3'b111};
  endfunction

  // floor: -12 dB + 6 dB per code -> gain code 8k
  function automatic logic [GAIN_W-1:0] floor_code(input logic [2:0] k);
    return {k, 3'b000};
  endfunction

endpackage

// File: rtl/agc_level_detect.sv
module agc_level_detect
  import agc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] smp,
  input  logic [3:0]           target_sel,
  input  logic                 gate_en,
  input  logic [2:0]           gate_sel,
  output logic                 loud,
  output logic                 gated
);

  localparam int SH = DW - 16;

  logic [DW-1:0] mag;
  logic [DW-1:0] tgt;
  logic [DW-1:0] gthr;
  logic [15:0]   gthr16;

  // magnitude; the most negative value maps to 2^(DW-1)
  always_comb begin
    if (smp[DW-1]) mag = $unsigned(-smp);
    else           mag = $unsigned(smp);
  end

  assign gthr16 = GATE_BASE16 >> gate_sel;

  generate
    if (SH == 0) begin : g_native
      assign tgt  = tgt_amp16(target_sel);
      assign gthr = gthr16;
    end else begin : g_scaled
      assign tgt  = {tgt_amp16(target_sel), {SH{1'b0}}};
      assign gthr = {gthr16, {SH{1'b0}}};
    end
  endgenerate

  assign loud  = (mag > tgt);
  assign gated = gate_en && !loud && (mag < gthr);

  // R9
  most_neg_loud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp == {1'b1, {(DW-1){1'b0}}}) |-> loud);

endmodule

// File: rtl/agc_period_sel.sv
module agc_period_sel #(
  parameter int HOLD_BASE = 4,
  parameter int ATK_ALC   = 8,
  parameter int DCY_ALC   = 32,
  parameter int ATK_LIM   = 2,
  parameter int DCY_LIM   = 8,
  parameter int HW        = 17,
  parameter int PW        = 16
) (
  input  logic          lim_mode,
  input  logic [3:0]    hold_sel,
  input  logic [3:0]    attack_sel,
  input  logic [3:0]    decay_sel,
  output logic [HW-1:0] hold_len,
  output logic [PW-1:0] atk_len,
  output logic [PW-1:0] dcy_len
);

  localparam logic [3:0] RATE_CAP = 4'd10;

  logic [1:0][3:0]    code;
  logic [1:0][PW-1:0] len;

  assign code = {decay_sel, attack_sel};

  // index 0 = attack, index 1 = decay
  for (genvar i = 0; i < 2; i++) begin : g_rate
    localparam int ALC_B = (i == 0) ? ATK_ALC : DCY_ALC;
    localparam int LIM_B = (i == 0) ? ATK_LIM : DCY_LIM;
    logic [3:0]    eff;
    logic [PW-1:0] base;
    assign eff    = (code[i] > RATE_CAP) ? RATE_CAP : code[i];
    assign base   = lim_mode ? PW'(LIM_B) : PW'(ALC_B);
    assign len[i] = base << eff;
  end

  assign atk_len = len[0];
  assign dcy_len = len[1];

  always_comb begin
    if (hold_sel == 4'd0) hold_len = '0;
    else                  hold_len = HW'(HOLD_BASE) << (hold_sel - 4'd1);
  end

endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int HW = 17,
  parameter int PW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alc_en,
  input  logic              smp_vld,
  input  logic              loud,
  input  logic              gated,
  input  logic [GAIN_W-1:0] manual_gain,
  input  logic [2:0]        max_sel,
  input  logic [2:0]        min_sel,
  input  logic [HW-1:0]     hold_len,
  input  logic [PW-1:0]     atk_len,
  input  logic [PW-1:0]     dcy_len,
  output logic [GAIN_W-1:0] gain_code,
  output logic              gate_active
);

  logic [GAIN_W-1:0] gain_q, gain_d;
  logic [HW-1:0]     hold_q, hold_d;
  logic [PW-1:0]     atk_q, atk_d;
  logic [PW-1:0]     dcy_q, dcy_d;
  logic              gate_q, gate_d;
  logic [GAIN_W-1:0] max_c, min_c;
  logic [GAIN_W-1:0] stepped;

  assign max_c = ceil_code(max_sel);
  assign min_c = floor_code(min_sel);

  always_comb begin
    gain_d  = gain_q;
    hold_d  = hold_q;
    atk_d   = atk_q;
    dcy_d   = dcy_q;
    gate_d  = gate_q;
    stepped = gain_q;
    if (!alc_en) begin
      gain_d = manual_gain;
      hold_d = '0;
      atk_d  = '0;
      dcy_d  = '0;
      gate_d = 1'b0;
    end else if (smp_vld) begin
      gate_d = 1'b0;
      if (loud) begin
        hold_d = '0;
        dcy_d  = '0;
        if (atk_q + PW'(1) >= atk_len) begin
          atk_d = '0;
          if (gain_q != '0) stepped = gain_q - 1'b1;
        end else begin
          atk_d = atk_q + PW'(1);
        end
      end else if (gated) begin
        atk_d  = '0;
        gate_d = 1'b1;
      end else begin
        atk_d = '0;
        if (hold_q < hold_len) begin
          hold_d = hold_q + HW'(1);
        end else if (dcy_q + PW'(1) >= dcy_len) begin
          dcy_d = '0;
          if (gain_q != GAIN_TOP) stepped = gain_q + 1'b1;
        end else begin
          dcy_d = dcy_q + PW'(1);
        end
      end
      if (stepped < min_c) stepped = min_c;
      if (stepped > max_c) stepped = max_c;
      gain_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_UNITY;
      hold_q <= '0;
      atk_q  <= '0;
      dcy_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      gain_q <= gain_d;
      hold_q <= hold_d;
      atk_q  <= atk_d;
      dcy_q  <= dcy_d;
      gate_q <= gate_d;
    end
  end

  assign gain_code   = gain_q;
  assign gate_active = gate_q;

  // R2
  manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alc_en |=> (gain_q == $past(manual_gain)) && !gate_q);

  // R3
  attack_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_en && smp_vld && loud && gain_q >= min_c) |=> gain_q <= $past(gain_q));

  // R7
  ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_en && smp_vld) |=> gain_q <= $past(max_c));

  // R8
  gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_en && smp_vld && gated && gain_q >= min_c && gain_q <= max_c)
      |=> (gain_q == $past(gain_q)) && gate_q);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_en && !smp_vld) |=> (gain_q == $past(gain_q)) && (gate_q == $past(gate_q)));

endmodule

// File: rtl/agc_noise_gate.sv
module agc_noise_gate
  import agc_pkg::*;
#(
  parameter int DW        = 16,
  parameter int HOLD_BASE = 4,
  parameter int ATK_ALC   = 8,
  parameter int DCY_ALC   = 32,
  parameter int ATK_LIM   = 2,
  parameter int DCY_LIM   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alc_en,
  input  logic                 lim_mode,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp,
  input  logic [5:0]           manual_gain,
  input  logic [2:0]           max_sel,
  input  logic [2:0]           min_sel,
  input  logic [3:0]           target_sel,
  input  logic [3:0]           hold_sel,
  input  logic [3:0]           attack_sel,
  input  logic [3:0]           decay_sel,
  input  logic                 gate_en,
  input  logic [2:0]           gate_sel,
  output logic [5:0]           gain_code,
  output logic                 gate_active
);

  localparam int BMAX_A = (ATK_ALC > DCY_ALC) ? ATK_ALC : DCY_ALC;
  localparam int BMAX_L = (ATK_LIM > DCY_LIM) ? ATK_LIM : DCY_LIM;
  localparam int BMAX   = (BMAX_A > BMAX_L) ? BMAX_A : BMAX_L;
  localparam int PW     = $clog2(BMAX) + 11;
  localparam int HW     = $clog2(HOLD_BASE) + 15;

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic          loud, gated;
  logic [HW-1:0] hold_len;
  logic [PW-1:0] atk_len, dcy_len;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  agc_level_detect #(.DW(DW)) u_lvl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .smp        (smp),
    .target_sel (target_sel),
    .gate_en    (gate_en),
    .gate_sel   (gate_sel),
    .loud       (loud),
    .gated      (gated)
  );

  agc_period_sel #(
    .HOLD_BASE (HOLD_BASE),
    .ATK_ALC   (ATK_ALC),
    .DCY_ALC   (DCY_ALC),
    .ATK_LIM   (ATK_LIM),
    .DCY_LIM   (DCY_LIM),
    .HW        (HW),
    .PW        (PW)
  ) u_per (
    .lim_mode   (lim_mode),
    .hold_sel   (hold_sel),
    .attack_sel (attack_sel),
    .decay_sel  (decay_sel),
    .hold_len   (hold_len),
    .atk_len    (atk_len),
    .dcy_len    (dcy_len)
  );

  agc_gain_ctrl #(.HW(HW), .PW(PW)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .alc_en      (alc_en),
    .smp_vld     (smp_vld),
    .loud        (loud),
    .gated       (gated),
    .manual_gain (manual_gain),
    .max_sel     (max_sel),
    .min_sel     (min_sel),
    .hold_len    (hold_len),
    .atk_len     (atk_len),
    .dcy_len     (dcy_len),
    .gain_code   (gain_code),
    .gate_active (gate_active)
  );

endmodule

// File: tb/agc_noise_gate_tb_top.sv
`timescale 1ns/1ps
module agc_noise_gate_tb_top;

  localparam int HOLD_BASE = 4;
  localparam int ATK_ALC = 8, DCY_ALC = 32, ATK_LIM = 2, DCY_LIM = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic alc_en, lim_mode, smp_vld, gate_en;
  logic signed [15:0] smp;
  logic [5:0] manual_gain;
  logic [2:0] max_sel, min_sel, gate_sel;
  logic [3:0] target_sel, hold_sel, attack_sel, decay_sel;
  logic [5:0] gain_code;
  logic gate_active;

  int vecs = 0, errs = 0;
  bit done = 0;
  string cur_req = "R1 reset";
  int m_gain, m_hold, m_atk, m_dcy, m_gate;

  always #2.5 clk = ~clk;

  agc_noise_gate #(
    .DW(16), .HOLD_BASE(HOLD_BASE), .ATK_ALC(ATK_ALC), .DCY_ALC(DCY_ALC),
    .ATK_LIM(ATK_LIM), .DCY_LIM(DCY_LIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .alc_en(alc_en), .lim_mode(lim_mode),
    .smp_vld(smp_vld), .smp(smp), .manual_gain(manual_gain),
    .max_sel(max_sel), .min_sel(min_sel), .target_sel(target_sel),
    .hold_sel(hold_sel), .attack_sel(attack_sel), .decay_sel(decay_sel),
    .gate_en(gate_en), .gate_sel(gate_sel),
    .gain_code(gain_code), .gate_active(gate_active)
  );

  function automatic real tgt_real(int sel);
    return 32768.0 * $pow(10.0, (-28.5 + 1.5 * sel) / 20.0);
  endfunction
  function automatic real gate_real(int sel);
    return 32768.0 * $pow(10.0, (-39.0 - 6.0 * sel) / 20.0);
  endfunction
  function automatic int db_code(real db);
    return $rtoi((db + 12.0) / 0.75 + 0.5);
  endfunction
  function automatic int rate_len(int base, int code);
    int c = (code > 10) ? 10 : code;
    return base * (2 ** c);
  endfunction
  function automatic int loud_amp(int sel);
    int a = $rtoi(tgt_real(sel) * 1.6) + 1;
    return (a > 32767) ? 32767 : a;
  endfunction
  function automatic int quiet_amp(int sel);
    return $rtoi(tgt_real(sel) * 0.6);
  endfunction
  function automatic int gated_amp(int sel);
    return $rtoi(gate_real(sel) * 0.5);
  endfunction

  task automatic model_update();
    int a, g, hl, lo, hi;
    bit ld, gt;
    if (!rst_n) begin
      m_gain = 16; m_hold = 0; m_atk = 0; m_dcy = 0; m_gate = 0;
    end else if (!alc_en) begin
      m_gain = manual_gain; m_hold = 0; m_atk = 0; m_dcy = 0; m_gate = 0;
    end else if (smp_vld) begin
      a  = (int'(smp) < 0) ? -int'(smp) : int'(smp);
      ld = real'(a) > tgt_real(target_sel);
      gt = gate_en && !ld && (real'(a) < gate_real(gate_sel));
      hl = (hold_sel == 0) ? 0 : HOLD_BASE * (2 ** (hold_sel - 1));
      g = m_gain;
      m_gate = 0;
      if (ld) begin
        m_hold = 0; m_dcy = 0;
        if (m_atk + 1 >= rate_len(lim_mode ? ATK_LIM : ATK_ALC, attack_sel)) begin
          m_atk = 0;
          if (g > 0) g--;
        end else m_atk++;
      end else if (gt) begin
        m_atk = 0; m_gate = 1;
      end else begin
        m_atk = 0;
        if (m_hold < hl) m_hold++;
        else if (m_dcy + 1 >= rate_len(lim_mode ? DCY_LIM : DCY_ALC, decay_sel)) begin
          m_dcy = 0;
          if (g < 63) g++;
        end else m_dcy++;
      end
      lo = db_code(-12.0 + 6.0 * min_sel);
      hi = db_code(-6.75 + 6.0 * max_sel);
      if (g < lo) g = lo;
      if (g > hi) g = hi;
      m_gain = g;
    end
  endtask

  task automatic compare();
    vecs++;
    if (gain_code !== 6'(m_gain) || gate_active !== 1'(m_gate)) begin
      errs++;
      $display("FAIL %s at %0t: gain=%0d gate=%0d expected gain=%0d gate=%0d",
               cur_req, $time, gain_code, gate_active, m_gain, m_gate);
    end
  endtask

  task automatic cyc();
    model_update();
    @(negedge clk);
    compare();
  endtask

  // kind: 0 loud, 1 quiet, 2 gated, 3 most negative; strobe every `gap` cycles
  task automatic run(int n, int kind, int gap);
    for (int i = 0; i < n; i++) begin
      int a;
      smp_vld = ((i % gap) == 0);
      case (kind)
        0: a = loud_amp(target_sel);
        1: a = quiet_amp(target_sel);
        2: a = gated_amp(gate_sel);
        default: a = 32768;
      endcase
      if (kind == 3) smp = 16'sh8000;
      else smp = ($urandom_range(0, 1) == 1) ? 16'(-a) : 16'(a);
      cyc();
    end
    smp_vld = 1'b0;
  endtask

  task automatic set_manual(int g);
    alc_en = 1'b0; manual_gain = 6'(g); smp_vld = 1'b0;
    cyc(); cyc();
    alc_en = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; alc_en = 1'b0; lim_mode = 1'b0; smp_vld = 1'b0; smp = '0;
    manual_gain = 6'd16; max_sel = 3'd7; min_sel = 3'd0; target_sel = 4'd5;
    hold_sel = 4'd0; attack_sel = 4'd1; decay_sel = 4'd0; gate_en = 1'b0;
    gate_sel = 3'd2;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1 reset";
    for (int i = 0; i < 4; i++) cyc();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc();

    // R2 manual gain while disabled
    cur_req = "R2 manual";
    for (int i = 0; i < 6; i++) begin
      manual_gain = 6'(i * 11 + 3);
      smp_vld = 1'b1; smp = 16'sd30000;
      cyc();
    end
    set_manual(40);

    // R3 attack, with strobe gaps (R10)
    cur_req = "R3 attack";
    run(120, 0, 1);
    cur_req = "R10 strobe gaps";
    run(60, 0, 3);

    // R4 hold then R5 decay
    cur_req = "R4 hold";
    hold_sel = 4'd3;
    run(20, 1, 1);
    cur_req = "R5 decay";
    run(500, 1, 1);
    cur_req = "R4 hold after attack";
    run(10, 0, 1);
    run(300, 1, 2);

    // R6 limiter mode
    cur_req = "R6 limiter";
    lim_mode = 1'b1;
    run(80, 0, 1);
    run(200, 1, 1);
    attack_sel = 4'd3; decay_sel = 4'd2;
    run(100, 0, 1);
    run(150, 1, 1);
    lim_mode = 1'b0; attack_sel = 4'd1; decay_sel = 4'd0;

    // R8 noise gate
    cur_req = "R8 gate";
    set_manual(30);
    gate_en = 1'b1;
    for (int s = 0; s < 8; s++) begin
      gate_sel = 3'(s);
      run(40, 2, 1);
      run(30, 1, 1);
    end
    run(20, 0, 1);
    gate_en = 1'b0;
    run(20, 2, 1);

    // R7 bounds
    cur_req = "R7 bounds";
    set_manual(50);
    max_sel = 3'd1;
    run(3, 1, 1);
    min_sel = 3'd6;
    run(3, 0, 1);
    min_sel = 3'd3; max_sel = 3'd7;
    set_manual(5);
    run(3, 0, 1);
    run(200, 1, 1);
    min_sel = 3'd0;

    // R9 most negative sample
    cur_req = "R9 most negative";
    target_sel = 4'd15; attack_sel = 4'd0;
    set_manual(40);
    run(40, 3, 1);
    target_sel = 4'd5;

    // R11 rate code saturation
    cur_req = "R11 decay cap";
    hold_sel = 4'd0; decay_sel = 4'd11;
    set_manual(30);
    run(33000, 1, 1);
    cur_req = "R11 attack cap";
    lim_mode = 1'b1; attack_sel = 4'd12;
    run(2200, 0, 1);
    lim_mode = 1'b0; attack_sel = 4'd1; decay_sel = 4'd0;

    // mixed traffic over R3 R5 R6 R7 R8
    cur_req = "R3 R5 R6 R7 R8 mixed";
    for (int blk = 0; blk < 60; blk++) begin
      lim_mode   = 1'($urandom_range(0, 1));
      gate_en    = 1'($urandom_range(0, 1));
      gate_sel   = 3'($urandom_range(0, 7));
      target_sel = 4'($urandom_range(0, 15));
      hold_sel   = 4'($urandom_range(0, 3));
      attack_sel = 4'($urandom_range(0, 2));
      decay_sel  = 4'($urandom_range(0, 2));
      max_sel    = 3'($urandom_range(2, 7));
      min_sel    = 3'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) set_manual($urandom_range(0, 63));
      for (int i = 0; i < 100; i++) begin
        int k = $urandom_range(0, 2);
        run(1, k, 1);
        if ($urandom_range(0, 3) == 0) begin smp_vld = 1'b0; cyc(); end
      end
    end

    finish_run();
  end

endmodule